// File: doc/BRIEF.md
# Compare-Channel Interval Timer with Watchdog Reset

This block keeps a free-running up-counter that advances by one on each cycle where a single-cycle reference tick is high. Four compare registers sit beside it. Each compare channel watches the counter and latches a sticky status flag when a tick carries the counter onto its compare value exactly. A flag reaches that channel's interrupt line only while the channel's interrupt enable is set. Software clears a flag by writing 1 to it.

The highest-numbered channel doubles as a watchdog. After software arms it, a match on that channel also raises a reset request, which records the watchdog as the cause of the coming reset. The arm bit cannot be cleared by software, and the reset request stays high until the block itself is reset. The other three channels are plain interval timers. Software reaches everything through a word-addressed register port with a write strobe and a combinational read path.

Register map (word addresses): 0 counter, 1 to 4 compare channels 0 to 3, 5 status flags (bit i = channel i, write 1 to clear), 6 interrupt enables (bit i = channel i), 7 watchdog arm (bit 0).

Top module: `match_timer`

## Requirements
- R1: After reset the counter, all compare values, status flags, interrupt enables and the arm bit read 0, and `irq` and `wdog_rst_req` are low.
- R2: The counter (address 0) advances by exactly one on each clock edge where `tick` is high and the counter is not being written, and holds its value on every other edge.
- R3: A write to address 0 loads the counter. A write wins over a tick in the same cycle, and later ticks count up from the loaded value.
- R4: The counter wraps from 0xFFFFFFFF to 0 and sets no status flag, except a flag whose compare value is 0.
- R5: Status bit i (address 5) is set on the edge where a tick moves the counter onto compare value i. Loading the counter directly with that value, or writing the compare value, does not set it.
- R6: Writing 1 to status bit i clears it, and writing 0 leaves it unchanged. If a match and a clear land on the same edge, the match wins and the bit stays 1.
- R7: `irq[i]` is high exactly when status bit i and interrupt enable bit i (address 6) are both 1.
- R8: Writing 1 to bit 0 of address 7 arms the watchdog. Writing 0 there has no effect, and only reset disarms it.
- R9: A match on channel 3 while the watchdog is armed raises `wdog_rst_req` on the same edge as the status flag. The request then stays high until reset, even after the flag is cleared. A match while disarmed leaves the request low.
- R10: Compare registers at addresses 1 to 4 and the enable register read back the values last written, each independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle count enable from the slow reference |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 4 | Per-channel interrupt lines |
| wdog_rst_req | output | 1 | Watchdog reset request, sticky until reset |

## Verification
The hardest case to reach is a compare match and a software clear of the same status flag landing on one clock edge. The bench reaches it by placing the counter one below the compare value and then issuing the status write and the tick in a single cycle. The wrap corner is reached without counting through 2^32 states: the counter is loaded with 0xFFFFFFFE and then ticked twice. The watchdog's set-only arm bit is checked by trying to disarm it with a zero write before the match occurs.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int CNT_W  = 32;
    localparam int NUM_CH = 4;
    localparam int WD_CH  = NUM_CH - 1;

    // register map derived from the channel count
    localparam int ADDR_W    = $clog2(NUM_CH + 4);
    localparam int ADR_CNT   = 0;
    localparam int ADR_CMP0  = 1;
    localparam int ADR_STAT  = NUM_CH + 1;
    localparam int ADR_IEN   = NUM_CH + 2;
    localparam int ADR_WDEN  = NUM_CH + 3;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  data;
    } reg_wr_t;

    function automatic logic hits_addr(input reg_wr_t w, input int a);
        return w.wr && (int'(w.addr) == a);
    endfunction

endpackage

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         adv,
    output logic [W-1:0] cnt_nxt
);
    assign adv     = tick && !ld;
    assign cnt_nxt = cnt + W'(1);

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (adv) cnt <= cnt_nxt;
    end
endmodule

// File: rtl/mtmr_channel.sv
module mtmr_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    input  logic         adv,
    input  logic [W-1:0] cnt_nxt,
    input  logic         clr,
    input  logic         ien_wr,
    input  logic         ien_bit,
    output logic [W-1:0] cmp,
    output logic         status,
    output logic         ien,
    output logic         irq,
    output logic         hit
);
    assign hit = adv && (cnt_nxt == cmp);
    assign irq = status && ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp    <= '0;
            status <= 1'b0;
            ien    <= 1'b0;
        end else begin
            if (cmp_wr) cmp <= wdata;
            if (ien_wr) ien <= ien_bit;
            status <= hit || (status && !clr);
        end
    end
endmodule

// File: rtl/mtmr_wdog.sv
module mtmr_wdog (
    input  logic clk,
    input  logic rst,
    input  logic arm_wr,
    input  logic arm_bit,
    input  logic hit,
    output logic armed,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            req   <= 1'b0;
        end else begin
            armed <= armed || (arm_wr && arm_bit);
            req   <= req || (armed && hit);
        end
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import mtmr_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_NUM_CH = NUM_CH,
    parameter int P_WD_CH  = WD_CH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [P_CNT_W-1:0]  wdata,
    output logic [P_CNT_W-1:0]  rdata,
    output logic [P_NUM_CH-1:0] irq,
    output logic                wdog_rst_req
);
    reg_wr_t w;
    assign w = '{wr: wr_en, addr: addr, data: CNT_W'(wdata)};

    logic [P_CNT_W-1:0] cnt_q;
    logic [P_CNT_W-1:0] cnt_nxt;
    logic               adv;

    mtmr_counter #(.W(P_CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick),
        .ld(hits_addr(w, ADR_CNT)), .ld_val(wdata),
        .cnt(cnt_q), .adv(adv), .cnt_nxt(cnt_nxt)
    );

    logic [P_CNT_W-1:0]  cmp_q [P_NUM_CH];
    logic [P_NUM_CH-1:0] stat_q;
    logic [P_NUM_CH-1:0] ien_q;
    logic [P_NUM_CH-1:0] hit;

    for (genvar i = 0; i < P_NUM_CH; i++) begin : g_ch
        mtmr_channel #(.W(P_CNT_W)) u_ch (
            .clk(clk), .rst(rst),
            .cmp_wr(hits_addr(w, ADR_CMP0 + i)), .wdata(wdata),
            .adv(adv), .cnt_nxt(cnt_nxt),
            .clr(hits_addr(w, ADR_STAT) && wdata[i]),
            .ien_wr(hits_addr(w, ADR_IEN)), .ien_bit(wdata[i]),
            .cmp(cmp_q[i]), .status(stat_q[i]), .ien(ien_q[i]),
            .irq(irq[i]), .hit(hit[i])
        );
    end

    logic wd_armed;

    mtmr_wdog u_wd (
        .clk(clk), .rst(rst),
        .arm_wr(hits_addr(w, ADR_WDEN)), .arm_bit(wdata[0]),
        .hit(hit[P_WD_CH]), .armed(wd_armed), .req(wdog_rst_req)
    );

    always_comb begin
        rdata = '0;
        if (int'(addr) == ADR_CNT)       rdata = cnt_q;
        else if (int'(addr) == ADR_STAT) rdata = P_CNT_W'(stat_q);
        else if (int'(addr) == ADR_IEN)  rdata = P_CNT_W'(ien_q);
        else if (int'(addr) == ADR_WDEN) rdata = P_CNT_W'(wd_armed);
        else begin
            for (int i = 0; i < P_NUM_CH; i++)
                if (int'(addr) == ADR_CMP0 + i) rdata = cmp_q[i];
        end
    end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
    parameter int W  = 32,
    parameter int N  = 4,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  cnt,
    input logic [N-1:0]  status,
    input logic          armed,
    input logic          req
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == '0);

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_wr) |=> $stable(cnt)); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr) |=> ((cnt - $past(cnt)) == W'(1))); // R4

    AST_ARM_KEEP: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed); // R8

    AST_REQ_KEEP: assert property (@(posedge clk) disable iff (rst)
        req |=> req); // R9

    AST_REQ_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(armed)); // R9

    for (genvar i = 0; i < N; i++) begin : g_src
        AST_STAT_SRC: assert property (@(posedge clk) disable iff (rst)
            $rose(status[i]) |-> $past(tick)); // R5
    end
endmodule

bind match_timer match_timer_chk #(
    .W(P_CNT_W), .N(P_NUM_CH), .AW(mtmr_pkg::ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .cnt(cnt_q), .status(stat_q), .armed(wd_armed), .req(wdog_rst_req)
);

// File: tb/match_timer_bench.sv
module match_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        wdog_rst_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    match_timer u_match_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst_req(wdog_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, input logic [2:0] a, input logic [31:0] d, input bit tk);
        @(negedge clk);
        wr_en = wr; addr = a; wdata = d; tick = tk;
        @(posedge clk); #1;
        wr_en = 0; tick = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cyc(1, a, d, 0);
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 0, 1);
            cyc(0, 0, 0, 0);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(posedge clk); @(posedge clk); #1; rst = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v); chk("R1 reg reset", v, 0);
        end
        chk("R1 irq reset", 32'(irq), 0);
        chk("R1 req reset", 32'(wdog_rst_req), 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        do_reset();
        tk(3);
        rd(0, v); chk("R2 three ticks", v, 3);
        repeat (4) cyc(0, 0, 0, 0);
        rd(0, v); chk("R2 hold without tick", v, 3);
        cyc(0, 0, 0, 1); cyc(0, 0, 0, 1);
        rd(0, v); chk("R2 back-to-back ticks", v, 5);
    endtask

    task automatic t_load();
        logic [31:0] v;
        do_reset();
        wr(0, 100);
        rd(0, v); chk("R3 load", v, 100);
        tk(1);
        rd(0, v); chk("R3 count from load", v, 101);
        cyc(1, 0, 500, 1);
        rd(0, v); chk("R3 write beats tick", v, 500);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 4; i++) wr(3'(1 + i), 32'(5 + i));
        wr(0, 32'hFFFF_FFFE);
        tk(1);
        rd(0, v); chk("R4 at max", v, 32'hFFFF_FFFF);
        tk(1);
        rd(0, v); chk("R4 wrapped", v, 0);
        rd(5, v); chk("R4 no flag on wrap", v, 0);
        wr(1, 0); wr(0, 32'hFFFF_FFFF); tk(1);
        rd(5, v); chk("R4 zero compare hits on wrap", v, 1);
    endtask

    task automatic t_match();
        logic [31:0] v;
        do_reset();
        wr(1, 10); wr(2, 20); wr(3, 30); wr(4, 40);
        wr(0, 9);
        rd(5, v); chk("R5 no flag before match", v, 0);
        tk(1);
        rd(5, v); chk("R5 tick onto compare 0", v, 1);
        wr(0, 20);
        rd(5, v); chk("R5 load onto compare 1 no flag", v, 1);
        wr(0, 29); tk(1);
        rd(5, v); chk("R5 tick onto compare 2", v, 5);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        do_reset();
        wr(1, 10); wr(0, 9); tk(1);
        wr(5, 0);
        rd(5, v); chk("R6 write 0 keeps flag", v, 1);
        wr(5, 1);
        rd(5, v); chk("R6 write 1 clears flag", v, 0);
        wr(0, 9);
        cyc(1, 5, 1, 1);
        rd(5, v); chk("R6 match wins over clear", v, 1);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        do_reset();
        wr(2, 7); wr(0, 6); tk(1);
        chk("R7 irq masked", 32'(irq), 0);
        wr(6, 32'h2);
        rd(6, v); chk("R10 enable readback", v, 2);
        chk("R7 irq enabled", 32'(irq), 2);
        wr(6, 32'hD);
        chk("R7 other enables no irq", 32'(irq), 0);
        wr(6, 32'hF); wr(5, 32'h2);
        chk("R7 irq drops on clear", 32'(irq), 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 4; i++) wr(3'(1 + i), 32'hA5A0_0000 + 32'(i * 3 + 1));
        for (int i = 0; i < 4; i++) begin
            rd(3'(1 + i), v); chk("R10 compare readback", v, 32'hA5A0_0000 + 32'(i * 3 + 1));
        end
    endtask

    task automatic t_wdog();
        logic [31:0] v;
        do_reset();
        wr(4, 3); tk(3);
        rd(5, v); chk("R9 disarmed match flag", v, 8);
        chk("R9 disarmed no request", 32'(wdog_rst_req), 0);
        do_reset();
        wr(7, 1); wr(7, 0);
        rd(7, v); chk("R8 arm survives zero write", v, 1);
        wr(4, 2); tk(1);
        chk("R9 no request before match", 32'(wdog_rst_req), 0);
        tk(1);
        chk("R9 request on match", 32'(wdog_rst_req), 1);
        wr(5, 32'h8);
        chk("R9 request sticky after clear", 32'(wdog_rst_req), 1);
        do_reset();
        rd(7, v); chk("R8 reset disarms", v, 0);
        chk("R9 reset drops request", 32'(wdog_rst_req), 0);
    endtask

    initial begin
        t_reset();
        t_count();
        t_load();
        t_wrap();
        t_match();
        t_clear();
        t_irq();
        t_readback();
        t_wdog();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule